// File: doc/BRIEF.md
# Parallel EEPROM Page Programmer

This controller sits on the host side of an asynchronous parallel EEPROM bus and writes one page per command. A requester supplies a start pulse, a page number and a byte count between 1 and the page size. The bytes sit in a small buffer. The controller reads that buffer through an index output and a data input. For each command, the controller first sends the three keyed unlock writes that the memory expects. It then loads the bytes into consecutive offsets of the chosen page, starting at offset 0. Each write is a CE-low strobe with the address and data held steady around the WE-low window.

After the final load, the controller stops writing and polls. It issues reads at the last loaded address and compares the returned bit 7 with bit 7 of the last byte. During programming the memory returns the inverse of that bit. When the bits match, programming is over and `done_o` pulses for one clock. If no match arrives within `POLL_TIMEOUT` clocks, `fail_o` pulses instead. In both cases the controller returns to idle. Write data leaves on `mem_dout_o` and read data arrives on `mem_din_i`. The pad logic enables the data driver while `mem_oe_n_o` is high and `mem_ce_n_o` is low.

The state sequence is fixed:
- IDLE → UNLOCK1 on a valid start.
- UNLOCK1 → UNLOCK2 → UNLOCK3 → LOAD, each step taken when its strobe ends.
- LOAD → LOAD after each byte that is not the last.
- LOAD → POLL after the last byte.
- POLL → DONE on a bit-7 match.
- POLL → ERROR when the poll timeout expires.
- DONE → IDLE and ERROR → IDLE after one clock each.

Top module: `eeprom_page_prog`

## Requirements
- R1: After reset, and whenever the controller is idle, `mem_ce_n_o`, `mem_we_n_o` and `mem_oe_n_o` are high, and `busy_o`, `done_o` and `fail_o` are low.
- R2: The controller acts on `start_i` only in IDLE and only when `count_i` lies in 1..PAGE_BYTES. A start at any other time, or with a count of 0 or above PAGE_BYTES, causes no bus write.
- R3: Every command begins with exactly three writes, in this order: data 0xAA at address 0x1555, then 0x55 at 0x0AAA, then 0xA0 at 0x1555.
- R4: The unlock writes are followed by exactly `count_i` data writes. Write k goes to address {page_i, k} (page in address bits 12..6, offset in bits 5..0) for k = 0..count−1, ascending. It carries buffer entry k, read while `buf_idx_o` = k.
- R5: While `mem_we_n_o` is low, `mem_ce_n_o` is low and `mem_oe_n_o` is high. Each WE-low window lasts exactly WP_LOW_CYC clocks.
- R6: `mem_addr_o` and `mem_dout_o` do not change from the clock before WE falls through the whole WE-low window.
- R7: Consecutive WE rising edges within one command are exactly 1+SETUP_CYC+WP_LOW_CYC+WP_HIGH_CYC clocks apart. This keeps the spacing far below the memory's byte-load limit.
- R8: After the last load, the controller reads the last loaded address with WE high, CE low and OE low. It finishes only when the returned bit 7 equals bit 7 of the last loaded byte.
- R9: `done_o` is a single-clock pulse, and the clock after it the controller is idle.
- R10: If no bit-7 match occurs within POLL_TIMEOUT clocks of polling, `fail_o` pulses for one clock. `done_o` stays low, and the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a page program command |
| page_i | input | 7 | Page number (address bits 12..6) |
| count_i | input | 7 | Number of bytes, 1..64 |
| buf_idx_o | output | 6 | Index of the requested buffer byte |
| buf_data_i | input | 8 | Buffer byte at `buf_idx_o` |
| mem_addr_o | output | 13 | Memory address |
| mem_dout_o | output | 8 | Write data towards the memory |
| mem_din_i | input | 8 | Read data from the memory |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_we_n_o | output | 1 | Write enable strobe, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-clock completion pulse |
| fail_o | output | 1 | One-clock poll-timeout pulse |

## Verification
The hardest case to reach from the ports is the poll timeout. The memory must keep returning the inverted bit 7 for longer than the whole timeout, which a well-behaved memory never does. The bench's memory model has a stuck switch that freezes its programming timer, so polling continues until ERROR is forced. Afterwards the switch is released and the model finishes, leaving a clean state for later commands. A second subtle case is a poll that would match too early. It is exposed by loading bytes whose bit 7 equals the old content while the model starts programming only on the first read.

// File: rtl/epp_pkg.sv
package epp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLOCK1,
        ST_UNLOCK2,
        ST_UNLOCK3,
        ST_LOAD,
        ST_POLL,
        ST_DONE,
        ST_ERROR
    } epp_state_t;

    typedef enum logic [1:0] {
        PH_OFF,
        PH_SETUP,
        PH_LOW,
        PH_HIGH
    } epp_phase_t;

    // keyed unlock preamble: address and data of each step
    localparam logic [12:0] KEY_ADDR_A = 13'h1555;
    localparam logic [12:0] KEY_ADDR_B = 13'h0AAA;
    localparam logic [7:0]  KEY_DATA_1 = 8'hAA;
    localparam logic [7:0]  KEY_DATA_2 = 8'h55;
    localparam logic [7:0]  KEY_DATA_3 = 8'hA0;

endpackage

// File: rtl/epp_strobe.sv
module epp_strobe
    import epp_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int LOW_CYC   = 3,
    parameter int HIGH_CYC  = 2,
    localparam int MAX_CYC  = (SETUP_CYC > LOW_CYC) ?
                              ((SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC) :
                              ((LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC),
    localparam int CW       = $clog2(MAX_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic we_n_o,
    output logic busy_o,
    output logic done_o
);

    epp_phase_t    phase_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_OFF;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_OFF: begin
                    if (go_i) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= CW'(SETUP_CYC - 1);
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_LOW;
                        cnt_q   <= CW'(LOW_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_LOW: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_HIGH;
                        cnt_q   <= CW'(HIGH_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_OFF;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= PH_OFF;
            endcase
        end
    end

    always_comb begin
        we_n_o = (phase_q != PH_LOW);
        busy_o = (phase_q != PH_OFF);
        done_o = (phase_q == PH_HIGH) && (cnt_q == '0);
    end

endmodule

// File: rtl/epp_timeout.sv
module epp_timeout #(
    parameter int LIMIT = 4096,
    localparam int TW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != TW'(LIMIT - 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == TW'(LIMIT - 1));

endmodule

// File: rtl/eeprom_page_prog.sv
module eeprom_page_prog
    import epp_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 64,
    parameter int SETUP_CYC    = 1,
    parameter int WP_LOW_CYC   = 3,
    parameter int WP_HIGH_CYC  = 2,
    parameter int READ_CYC     = 3,
    parameter int POLL_TIMEOUT = 4096,
    localparam int OFFS_W      = $clog2(PAGE_BYTES),
    localparam int PAGE_W      = ADDR_W - OFFS_W,
    localparam int CNT_W       = OFFS_W + 1,
    localparam int RD_W        = $clog2(READ_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [OFFS_W-1:0] buf_idx_o,
    input  logic [DATA_W-1:0] buf_data_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_dout_o,
    input  logic [DATA_W-1:0] mem_din_i,
    output logic              mem_ce_n_o,
    output logic              mem_we_n_o,
    output logic              mem_oe_n_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o
);

    epp_state_t        state_q;
    logic [PAGE_W-1:0] page_q;
    logic [CNT_W-1:0]  count_q;
    logic [OFFS_W-1:0] idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              issued_q;
    logic [RD_W-1:0]   poll_cnt_q;

    logic              go;
    logic              stb_busy;
    logic              stb_done;
    logic              tmo_expired;
    logic              start_ok;
    logic              last_byte;
    logic              poll_sample;
    logic              poll_match;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    epp_strobe #(
        .SETUP_CYC (SETUP_CYC),
        .LOW_CYC   (WP_LOW_CYC),
        .HIGH_CYC  (WP_HIGH_CYC)
    ) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go),
        .we_n_o (mem_we_n_o),
        .busy_o (stb_busy),
        .done_o (stb_done)
    );

    epp_timeout #(
        .LIMIT (POLL_TIMEOUT)
    ) u_timeout (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == ST_POLL),
        .expired_o (tmo_expired)
    );

    assign start_ok    = start_i && (count_i != '0) && (count_i <= CNT_W'(PAGE_BYTES));
    assign last_byte   = (CNT_W'(idx_q) == count_q - CNT_W'(1));
    assign poll_sample = (state_q == ST_POLL) && (poll_cnt_q == RD_W'(READ_CYC));
    assign poll_match  = (mem_din_i[DATA_W-1] == data_q[DATA_W-1]);

    // address and data presented for the write of the current state
    always_comb begin
        wr_addr = {page_q, idx_q};
        wr_data = buf_data_i;
        unique case (state_q)
            ST_UNLOCK1: begin
                wr_addr = ADDR_W'(KEY_ADDR_A);
                wr_data = DATA_W'(KEY_DATA_1);
            end
            ST_UNLOCK2: begin
                wr_addr = ADDR_W'(KEY_ADDR_B);
                wr_data = DATA_W'(KEY_DATA_2);
            end
            ST_UNLOCK3: begin
                wr_addr = ADDR_W'(KEY_ADDR_A);
                wr_data = DATA_W'(KEY_DATA_3);
            end
            default: begin
                wr_addr = {page_q, idx_q};
                wr_data = buf_data_i;
            end
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            page_q     <= '0;
            count_q    <= '0;
            idx_q      <= '0;
            addr_q     <= '0;
            data_q     <= '0;
            issued_q   <= 1'b0;
            poll_cnt_q <= '0;
        end else begin
            if (go) begin
                addr_q   <= wr_addr;
                data_q   <= wr_data;
                issued_q <= 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        page_q  <= page_i;
                        count_q <= count_i;
                        idx_q   <= '0;
                        state_q <= ST_UNLOCK1;
                    end
                end
                ST_UNLOCK1: begin
                    if (stb_done) begin
                        issued_q <= 1'b0;
                        state_q  <= ST_UNLOCK2;
                    end
                end
                ST_UNLOCK2: begin
                    if (stb_done) begin
                        issued_q <= 1'b0;
                        state_q  <= ST_UNLOCK3;
                    end
                end
                ST_UNLOCK3: begin
                    if (stb_done) begin
                        issued_q <= 1'b0;
                        state_q  <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (stb_done) begin
                        issued_q <= 1'b0;
                        if (last_byte) begin
                            poll_cnt_q <= '0;
                            state_q    <= ST_POLL;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_POLL: begin
                    if (poll_sample && poll_match) begin
                        state_q <= ST_DONE;
                    end else if (tmo_expired) begin
                        state_q <= ST_ERROR;
                    end else if (poll_sample) begin
                        poll_cnt_q <= '0;
                    end else begin
                        poll_cnt_q <= poll_cnt_q + 1'b1;
                    end
                end
                ST_DONE:  state_q <= ST_IDLE;
                ST_ERROR: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        go         = 1'b0;
        mem_ce_n_o = 1'b1;
        mem_oe_n_o = 1'b1;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        fail_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_UNLOCK1, ST_UNLOCK2, ST_UNLOCK3, ST_LOAD: begin
                mem_ce_n_o = 1'b0;
                go         = !issued_q && !stb_busy;
            end
            ST_POLL: begin
                mem_ce_n_o = 1'b0;
                mem_oe_n_o = (poll_cnt_q == '0);
            end
            ST_DONE:  done_o = 1'b1;
            ST_ERROR: fail_o = 1'b1;
            default:  busy_o = 1'b1;
        endcase
    end

    assign mem_addr_o = addr_q;
    assign mem_dout_o = data_q;
    assign buf_idx_o  = idx_q;

endmodule

// File: rtl/eeprom_page_prog_sva.sv
module eeprom_page_prog_sva #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_dout_o,
    input logic              mem_ce_n_o,
    input logic              mem_we_n_o,
    input logic              mem_oe_n_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              fail_o
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (mem_ce_n_o && mem_we_n_o && mem_oe_n_o && !done_o && !fail_o));

    assert_strobe_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> (!mem_ce_n_o && mem_oe_n_o));

    assert_bus_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> ($stable(mem_addr_o) && $stable(mem_dout_o)));

    assert_poll_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> (mem_we_n_o && !mem_ce_n_o));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    assert_fail_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> (!fail_o && !busy_o));

    assert_outcome_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fail_o}));

endmodule

bind eeprom_page_prog eeprom_page_prog_sva #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr_o (mem_addr_o),
    .mem_dout_o (mem_dout_o),
    .mem_ce_n_o (mem_ce_n_o),
    .mem_we_n_o (mem_we_n_o),
    .mem_oe_n_o (mem_oe_n_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
);

// File: tb/tb_eeprom_page_prog.sv
module tb_eeprom_page_prog;

    localparam int SETUP_CYC    = 1;
    localparam int WP_LOW       = 3;
    localparam int WP_HIGH      = 2;
    localparam int READ_CYC     = 3;
    localparam int POLL_TIMEOUT = 1500;
    localparam int PERIOD_CYC   = 1 + SETUP_CYC + WP_LOW + WP_HIGH;
    localparam int LOAD_LIMIT   = 40;
    localparam int WC_CYC       = 300;
    localparam int WATCHDOG     = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  page_i = '0;
    logic [6:0]  count_i = '0;
    logic [5:0]  buf_idx_o;
    logic [7:0]  buf_data_i;
    logic [12:0] mem_addr_o;
    logic [7:0]  mem_dout_o;
    logic [7:0]  mem_din_i;
    logic        mem_ce_n_o, mem_we_n_o, mem_oe_n_o;
    logic        busy_o, done_o, fail_o;

    int total = 0;
    int bad   = 0;

    // bench-side buffer and memory model
    logic [7:0]  buf_mem [64];
    logic [7:0]  mem [512];
    logic [7:0]  pend_data [64];
    logic        pend_v [64];
    logic [12:0] log_addr [80];
    logic [7:0]  log_data [80];
    int          log_n;
    int          cyc = 0;
    int          step, last_write, last_rise, rise_cnt, low_len, prog_timer;
    logic        loaded, prog_busy, stuck;
    logic [12:0] last_addr, fall_addr;
    logic [7:0]  last_data, fall_data;
    logic        we_prev, oe_prev;
    int          viol_guard, viol_stable, viol_width, viol_gap, viol_early, viol_page;
    int          poll_reads, done_cnt, fail_cnt, done_while_prog;

    always #5 clk = ~clk;

    eeprom_page_prog #(
        .SETUP_CYC    (SETUP_CYC),
        .WP_LOW_CYC   (WP_LOW),
        .WP_HIGH_CYC  (WP_HIGH),
        .READ_CYC     (READ_CYC),
        .POLL_TIMEOUT (POLL_TIMEOUT)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .page_i     (page_i),
        .count_i    (count_i),
        .buf_idx_o  (buf_idx_o),
        .buf_data_i (buf_data_i),
        .mem_addr_o (mem_addr_o),
        .mem_dout_o (mem_dout_o),
        .mem_din_i  (mem_din_i),
        .mem_ce_n_o (mem_ce_n_o),
        .mem_we_n_o (mem_we_n_o),
        .mem_oe_n_o (mem_oe_n_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .fail_o     (fail_o)
    );

    assign buf_data_i = buf_mem[buf_idx_o];
    assign mem_din_i  = (prog_busy && mem_addr_o == last_addr) ?
                        {~last_data[7], last_data[6:0]} : mem[mem_addr_o[8:0]];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic commit_start();
        loaded     = 1'b0;
        prog_busy  = 1'b1;
        prog_timer = WC_CYC;
    endtask

    task automatic model_write(input logic [12:0] a, input logic [7:0] d);
        if (prog_busy) return;
        case (step)
            0: step = (a == 13'h1555 && d == 8'hAA) ? 1 : 0;
            1: step = (a == 13'h0AAA && d == 8'h55) ? 2 : 0;
            2: step = (a == 13'h1555 && d == 8'hA0) ? 3 : 0;
            default: begin
                if (loaded && a[12:6] != last_addr[12:6]) viol_page++;
                pend_data[a[5:0]] = d;
                pend_v[a[5:0]]    = 1'b1;
                last_addr  = a;
                last_data  = d;
                loaded     = 1'b1;
                last_write = cyc;
            end
        endcase
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (rst_n) begin
            if (!mem_we_n_o) begin
                if (we_prev) begin
                    low_len   = 0;
                    fall_addr = mem_addr_o;
                    fall_data = mem_dout_o;
                end
                low_len++;
                if (!mem_oe_n_o || mem_ce_n_o) viol_guard++;
                if (mem_addr_o != fall_addr || mem_dout_o != fall_data) viol_stable++;
            end
            if (mem_we_n_o && !we_prev) begin
                if (low_len != WP_LOW) viol_width++;
                if (rise_cnt > 0 && cyc - last_rise != PERIOD_CYC) viol_gap++;
                rise_cnt++;
                last_rise = cyc;
                if (log_n < 80) begin
                    log_addr[log_n] = fall_addr;
                    log_data[log_n] = mem_dout_o;
                end
                log_n++;
                model_write(fall_addr, mem_dout_o);
            end
            if (!mem_oe_n_o && oe_prev && !mem_ce_n_o) begin
                poll_reads++;
                if (loaded) commit_start();
            end
            if (loaded && cyc - last_write > LOAD_LIMIT) begin
                viol_early++;
                commit_start();
            end
            if (prog_busy && !stuck) begin
                if (prog_timer == 0) begin
                    for (int i = 0; i < 64; i++) begin
                        if (pend_v[i]) mem[{last_addr[8:6], 6'(i)}] = pend_data[i];
                        pend_v[i] = 1'b0;
                    end
                    prog_busy = 1'b0;
                    step      = 0;
                end else begin
                    prog_timer--;
                end
            end
            if (done_o) begin
                done_cnt++;
                if (prog_busy) done_while_prog++;
            end
            if (fail_o) fail_cnt++;
        end
        we_prev = mem_we_n_o;
        oe_prev = mem_oe_n_o;
    end

    task automatic clear_mon();
        log_n = 0; rise_cnt = 0;
        viol_guard = 0; viol_stable = 0; viol_width = 0; viol_gap = 0;
        viol_early = 0; viol_page = 0; poll_reads = 0;
        done_cnt = 0; fail_cnt = 0; done_while_prog = 0;
    endtask

    task automatic fill_buf(input int seed);
        for (int i = 0; i < 64; i++) buf_mem[i] = 8'((i * 37 + seed * 11) ^ (i << 7));
    endtask

    task automatic pulse_start(input int pg, input int cnt);
        @(negedge clk);
        page_i  = 7'(pg);
        count_i = 7'(cnt);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done_o || fail_o) break;
        end
        @(negedge clk);
    endtask

    // full set of checks after a command that should succeed
    task automatic check_op(input int pg, input int cnt, input string name);
        chk(log_n == 3 + cnt, {name, " R4 write count"}, log_n, 3 + cnt);
        chk(log_addr[0] == 13'h1555 && log_data[0] == 8'hAA, {name, " R3 key1"}, log_data[0], 8'hAA);
        chk(log_addr[1] == 13'h0AAA && log_data[1] == 8'h55, {name, " R3 key2"}, log_data[1], 8'h55);
        chk(log_addr[2] == 13'h1555 && log_data[2] == 8'hA0, {name, " R3 key3"}, log_data[2], 8'hA0);
        for (int k = 0; k < cnt; k++) begin
            if (log_addr[3 + k] != 13'((pg << 6) | k) || log_data[3 + k] != buf_mem[k])
                chk(1'b0, {name, " R4 load address/data"}, int'(log_addr[3 + k]), (pg << 6) | k);
            if (mem[9'(((pg & 7) << 6) | k)] != buf_mem[k])
                chk(1'b0, {name, " R4 stored byte"}, mem[9'(((pg & 7) << 6) | k)], buf_mem[k]);
        end
        chk(1'b1, {name, " R4 per-byte compare"}, 0, 0);
        chk(viol_guard == 0 && viol_width == 0, {name, " R5 strobe guard/width"}, viol_guard + viol_width, 0);
        chk(viol_stable == 0, {name, " R6 hold stable"}, viol_stable, 0);
        chk(viol_gap == 0 && viol_early == 0 && viol_page == 0, {name, " R7 spacing"},
            viol_gap + viol_early + viol_page, 0);
        chk(poll_reads > 0 && done_while_prog == 0, {name, " R8 polled to completion"},
            done_while_prog, 0);
        chk(done_cnt == 1 && fail_cnt == 0, {name, " R9 single done"}, done_cnt, 1);
        chk(!busy_o, {name, " R9 idle after done"}, busy_o, 0);
    endtask

    task automatic test_reset();
        chk(mem_ce_n_o && mem_we_n_o && mem_oe_n_o, "R1 strobes high at reset",
            {mem_ce_n_o, mem_we_n_o, mem_oe_n_o}, 7);
        chk(!busy_o && !done_o && !fail_o, "R1 status low at reset", {busy_o, done_o, fail_o}, 0);
    endtask

    task automatic test_single_byte();
        clear_mon(); fill_buf(1);
        mem[9'(3 << 6)] = buf_mem[0] ^ 8'h7F;   // same bit 7 as new data
        pulse_start(3, 1); wait_end();
        check_op(3, 1, "single");
    endtask

    task automatic test_partial_page();
        clear_mon(); fill_buf(2);
        pulse_start(1, 9); wait_end();
        check_op(1, 9, "partial");
    endtask

    task automatic test_full_page();
        clear_mon(); fill_buf(3);
        pulse_start(6, 64); wait_end();
        check_op(6, 64, "full");
    endtask

    task automatic test_bad_count();
        clear_mon();
        pulse_start(4, 0);
        repeat (10) @(negedge clk);
        chk(!busy_o && log_n == 0, "R2 count zero ignored", log_n, 0);
        pulse_start(4, 65);
        repeat (10) @(negedge clk);
        chk(!busy_o && log_n == 0, "R2 count above page ignored", log_n, 0);
    endtask

    task automatic test_start_while_busy();
        clear_mon(); fill_buf(4);
        pulse_start(2, 4);
        repeat (8) @(negedge clk);
        pulse_start(5, 2);
        wait_end();
        check_op(2, 4, "busy-start");
        chk(mem[9'(5 << 6)] == 8'hFF, "R2 start while busy ignored", mem[9'(5 << 6)], 8'hFF);
        repeat (10) @(negedge clk);
        chk(!busy_o && log_n == 7, "R2 no second command", log_n, 7);
    endtask

    task automatic test_timeout();
        int t0;
        clear_mon(); fill_buf(5);
        stuck = 1'b1;
        pulse_start(7, 3);
        t0 = cyc;
        wait_end();
        chk(fail_cnt == 1 && done_cnt == 0, "R10 fail without done", fail_cnt, 1);
        chk(cyc - t0 >= POLL_TIMEOUT, "R10 waited the full timeout", cyc - t0, POLL_TIMEOUT);
        chk(!busy_o, "R10 idle after fail", busy_o, 0);
        stuck = 1'b0;
        repeat (WC_CYC + 20) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        for (int i = 0; i < 64; i++) pend_v[i] = 1'b0;
        step = 0; loaded = 1'b0; prog_busy = 1'b0; stuck = 1'b0; prog_timer = 0;
        last_addr = '0; last_data = '0; fall_addr = '0; fall_data = '0;
        last_write = 0; last_rise = 0; low_len = 0;
        we_prev = 1'b1; oe_prev = 1'b1;
        clear_mon();
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_single_byte();
        test_partial_page();
        test_full_page();
        test_bad_count();
        test_start_while_busy();
        test_timeout();
        test_single_byte();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule